// File: doc/BRIEF.md
# Multiplexed Pixel Port Serializer

This block sits between a frame buffer and the color converters of a display pipeline. On every rising edge of a load strobe it captures a wide pixel-port word. In two-pixel mode the word holds two pixels, one from memory bank A and one from memory bank B. In single-pixel mode it holds one pixel. Each pixel carries 24 bits of RGB, a sync bit, a blank bit and a 2-bit palette-select code. The block then emits the captured pixels one per pixel-clock cycle.

The load strobe must be frequency-locked to the pixel clock, but its phase may be anything. A small dual-clock buffer carries the words into the pixel-clock domain. After reset, reading starts once the buffer holds half its depth, which makes the latency fixed from then on. For each pixel the block checks whether the select code equals a programmed match code. A pixel that does not match is dark: its color, blank and sync-on-green outputs are all zero. A matched pixel goes dark when blank or sync is active.

Sync leaves the block in two forms, each under its own enable. One is a flag that marks the pixel for sync-on-green encoding. The other is a standalone digital sync output with the same pipeline delay as the pixels. The block also drives a load clock output, which is the pixel clock divided by the mode ratio, so that it can be wired back to the load strobe. The mode and configuration inputs are static while the stream runs; change them only under reset.

Top module: `pixmux_serializer`

## Requirements
- R1: Every rising edge of `load_clk` after reset captures both banks' RGB, sync, blank and select bits, and the captured pixels leave the block in capture order with none lost or repeated.
- R2: With `ratio2`=1 each captured word yields two output pixels on consecutive pixel clocks, bank A first and bank B second, and the buffer is never read on two consecutive cycles.
- R3: With `ratio2`=0 each captured word yields exactly one output pixel (bank A), one per pixel clock, and the bank B inputs have no effect on any output.
- R4: A pixel is selected (`sel_o`=1) only when its 2-bit select equals `sel_code`. A deselected pixel gives `rgb_o`=0, `blank_o`=0 and `sog_o`=0, whatever its color, sync and blank inputs are.
- R5: For a selected pixel, `blank_o` equals its blank bit. `rgb_o` is zero when either blank or sync is 1, and equals the captured RGB value ({R,G,B}, R in the top byte) otherwise.
- R6: `sog_o` is 1 exactly when the pixel is selected, its sync bit is 1 and `sog_en`=1; with `sog_en`=0 the sync input never reaches `sog_o`.
- R7: `sync_o` equals the pixel's sync bit ANDed with `sync_pin_en`, regardless of selection. It appears in the same clock cycle as that pixel's other outputs.
- R8: `load_out` toggles on every pixel-clock rising edge when `ratio2`=1 (pixel clock ÷2), and equals `pix_clk` when `ratio2`=0.
- R9: After reset every output is zero and `run_o` is 0. `run_o` rises only once the buffer has gathered half its depth in words. Once `run_o` is high it stays high and a valid pixel appears on every cycle.
- R10: Correct output holds for any fixed phase between `load_clk` and `pix_clk`, as long as the two are frequency-locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock |
| load_clk | input | 1 | Load strobe; a word is captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ratio2 | input | 1 | 1: two pixels per word; 0: one pixel per word |
| sel_code | input | 2 | Match code for the per-pixel select bits |
| sog_en | input | 1 | Enables the sync-on-green flag |
| sync_pin_en | input | 1 | Enables the standalone digital sync output |
| a_rgb | input | 24 | Bank A color {R,G,B} |
| a_sync | input | 1 | Bank A sync |
| a_blank | input | 1 | Bank A blank |
| a_psel | input | 2 | Bank A palette select |
| b_rgb | input | 24 | Bank B color {R,G,B} |
| b_sync | input | 1 | Bank B sync |
| b_blank | input | 1 | Bank B blank |
| b_psel | input | 2 | Bank B palette select |
| load_out | output | 1 | Pixel clock divided by the mode ratio |
| run_o | output | 1 | High once the pixel stream has started |
| rgb_o | output | 24 | Output pixel color |
| blank_o | output | 1 | Output blank flag |
| sog_o | output | 1 | Sync-on-green flag |
| sel_o | output | 1 | Pixel selected flag |
| sync_o | output | 1 | Delay-matched digital sync |

## Verification
The assertions check the following on every cycle:
- Deselected pixels and blanked pixels are dark.
- The two enables gate their sync outputs.
- The read side never draws from an empty buffer and never reads on back-to-back cycles in two-pixel mode.
- The stream flag is sticky and the outputs stay quiet before the stream starts.
- The load clock output toggles every cycle in two-pixel mode.

Only the bench's scenarios can show the following:
- Pixels emerge in capture order, bank A before bank B.
- Sync stays in the same cycle as its pixel.
- The start threshold is respected.
- All of this holds under different strobe phases and in both modes.

// File: rtl/pixmux_pkg.sv
package pixmux_pkg;

    parameter int CH_W  = 8;
    localparam int RGB_W = 3 * CH_W;

    typedef struct packed {
        logic [RGB_W-1:0] rgb;
        logic             sync;
        logic             blank;
        logic [1:0]       psel;
    } pix_in_t;

    typedef struct packed {
        pix_in_t bank_b;
        pix_in_t bank_a;
    } word_t;

    typedef struct packed {
        logic [RGB_W-1:0] rgb;
        logic             blank;
        logic             sog;
        logic             sel;
        logic             sync_dig;
    } pix_out_t;

endpackage

// File: rtl/pixmux_cdc_fifo.sv
module pixmux_cdc_fifo
    import pixmux_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     wr_clk,
    input  logic                     rd_clk,
    input  logic                     rst_n,
    input  word_t                    wr_word,
    input  logic                     rd_en,
    output word_t                    rd_word,
    output logic [$clog2(DEPTH):0]   rd_fill
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } wptr_t;

    function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // write domain: one word per load edge, unconditionally
    wptr_t w_d, w_q;
    word_t mem_q [DEPTH];

    always_comb begin
        w_d.bin  = w_q.bin + 1'b1;
        w_d.gray = w_d.bin ^ (w_d.bin >> 1);
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    always_ff @(posedge wr_clk) begin
        mem_q[w_q.bin[AW-1:0]] <= wr_word;
    end

    // read domain
    logic [PW-1:0] sync_q [SYNC_STAGES];
    logic [PW-1:0] rptr_d, rptr_q;
    logic [PW-1:0] wseen;

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
        end else begin
            sync_q[0] <= w_q.gray;
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    always_comb begin
        wseen   = to_bin(sync_q[SYNC_STAGES-1]);
        rd_fill = wseen - rptr_q;
        rd_word = mem_q[rptr_q[AW-1:0]];
        rptr_d  = rptr_q + {{(PW-1){1'b0}}, rd_en};
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) rptr_q <= '0;
        else        rptr_q <= rptr_d;
    end

    // R9: the reader never consumes a word the writer has not published
    assert_no_underflow_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_en |-> (rd_fill != '0));

    // R1: the published write pointer moves by at most one gray bit per edge
    assert_gray_step_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $onehot0(w_q.gray ^ $past(w_q.gray)));

endmodule

// File: rtl/pixmux_shade.sv
module pixmux_shade
    import pixmux_pkg::*;
(
    input  pix_in_t    px,
    input  logic [1:0] match_code,
    input  logic       sog_en,
    input  logic       pin_en,
    output pix_out_t   shaded
);
    always_comb begin
        shaded          = '0;
        shaded.sync_dig = px.sync & pin_en;
        shaded.sel      = (px.psel == match_code);
        if (shaded.sel) begin
            shaded.blank = px.blank;
            shaded.sog   = px.sync & sog_en;
            shaded.rgb   = (px.blank | px.sync) ? '0 : px.rgb;
        end
    end
endmodule

// File: rtl/pixmux_loadout.sv
module pixmux_loadout (
    input  logic pix_clk,
    input  logic rst_n,
    input  logic ratio2,
    output logic load_out
);
    logic div_d, div_q;

    always_comb begin
        div_d    = ratio2 & ~div_q;
        load_out = ratio2 ? div_q : pix_clk;
    end

    always_ff @(posedge pix_clk or negedge rst_n) begin
        if (!rst_n) div_q <= 1'b0;
        else        div_q <= div_d;
    end

    assert_loadout_toggle_R8: assert property (@(posedge pix_clk) disable iff (!rst_n)
        ratio2 |=> (div_q != $past(div_q)));
endmodule

// File: rtl/pixmux_serializer.sv
module pixmux_serializer
    import pixmux_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             pix_clk,
    input  logic             load_clk,
    input  logic             rst_n,
    input  logic             ratio2,
    input  logic [1:0]       sel_code,
    input  logic             sog_en,
    input  logic             sync_pin_en,
    input  logic [RGB_W-1:0] a_rgb,
    input  logic             a_sync,
    input  logic             a_blank,
    input  logic [1:0]       a_psel,
    input  logic [RGB_W-1:0] b_rgb,
    input  logic             b_sync,
    input  logic             b_blank,
    input  logic [1:0]       b_psel,
    output logic             load_out,
    output logic             run_o,
    output logic [RGB_W-1:0] rgb_o,
    output logic             blank_o,
    output logic             sog_o,
    output logic             sel_o,
    output logic             sync_o
);
    localparam int FILL_W     = $clog2(DEPTH) + 1;
    localparam int START_FILL = DEPTH / 2;

    typedef struct packed {
        logic     started;
        logic     emitting;
        logic     phase;
        pix_in_t  held;
        pix_out_t out;
    } seq_t;

    seq_t              s_d, s_q;
    word_t             wr_word, rd_word;
    logic              rd_en;
    logic [FILL_W-1:0] rd_fill;
    pix_in_t           cur_px;
    pix_out_t          shaded;

    always_comb begin
        wr_word.bank_a.rgb   = a_rgb;
        wr_word.bank_a.sync  = a_sync;
        wr_word.bank_a.blank = a_blank;
        wr_word.bank_a.psel  = a_psel;
        wr_word.bank_b.rgb   = b_rgb;
        wr_word.bank_b.sync  = b_sync;
        wr_word.bank_b.blank = b_blank;
        wr_word.bank_b.psel  = b_psel;
    end

    pixmux_cdc_fifo #(
        .DEPTH       (DEPTH),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_fifo (
        .wr_clk  (load_clk),
        .rd_clk  (pix_clk),
        .rst_n   (rst_n),
        .wr_word (wr_word),
        .rd_en   (rd_en),
        .rd_word (rd_word),
        .rd_fill (rd_fill)
    );

    pixmux_shade u_shade (
        .px         (cur_px),
        .match_code (sel_code),
        .sog_en     (sog_en),
        .pin_en     (sync_pin_en),
        .shaded     (shaded)
    );

    pixmux_loadout u_loadout (
        .pix_clk  (pix_clk),
        .rst_n    (rst_n),
        .ratio2   (ratio2),
        .load_out (load_out)
    );

    always_comb begin
        s_d    = s_q;
        rd_en  = 1'b0;
        cur_px = s_q.held;
        if (!s_q.started) begin
            s_d.started = (rd_fill >= FILL_W'(START_FILL));
        end
        s_d.emitting = s_q.started;
        if (s_q.started) begin
            if (!s_q.phase) begin
                rd_en     = 1'b1;
                cur_px    = rd_word.bank_a;
                s_d.held  = rd_word.bank_b;
                s_d.phase = ratio2;
            end else begin
                cur_px    = s_q.held;
                s_d.phase = 1'b0;
            end
        end
        s_d.out = s_q.started ? shaded : '0;
    end

    always_ff @(posedge pix_clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        run_o   = s_q.emitting;
        rgb_o   = s_q.out.rgb;
        blank_o = s_q.out.blank;
        sog_o   = s_q.out.sog;
        sel_o   = s_q.out.sel;
        sync_o  = s_q.out.sync_dig;
    end

    assert_deselect_dark_R4: assert property (@(posedge pix_clk) disable iff (!rst_n)
        !sel_o |-> (rgb_o == '0 && !blank_o && !sog_o));

    assert_blank_dark_R5: assert property (@(posedge pix_clk) disable iff (!rst_n)
        blank_o |-> (rgb_o == '0));

    assert_sog_gated_R6: assert property (@(posedge pix_clk) disable iff (!rst_n)
        sog_o |-> (sog_en && sel_o));

    assert_sync_pin_gated_R7: assert property (@(posedge pix_clk) disable iff (!rst_n)
        sync_o |-> sync_pin_en);

    assert_alternate_reads_R2: assert property (@(posedge pix_clk) disable iff (!rst_n)
        (ratio2 && rd_en) |=> !rd_en);

    assert_run_sticks_R9: assert property (@(posedge pix_clk) disable iff (!rst_n)
        run_o |=> run_o);

    assert_idle_quiet_R9: assert property (@(posedge pix_clk) disable iff (!rst_n)
        !run_o |-> (rgb_o == '0 && !sync_o && !sel_o && !sog_o && !blank_o));

endmodule

// File: tb/pixmux_serializer_test.sv
`timescale 1ns/1ps
module pixmux_serializer_test;
    import pixmux_pkg::*;

    localparam int W = RGB_W + 4;

    logic             pix_clk = 1'b0;
    logic             load_clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ratio2 = 1'b1;
    logic [1:0]       sel_code = 2'd0;
    logic             sog_en = 1'b0;
    logic             sync_pin_en = 1'b0;
    logic [RGB_W-1:0] a_rgb = '0, b_rgb = '0;
    logic             a_sync = 1'b0, a_blank = 1'b0, b_sync = 1'b0, b_blank = 1'b0;
    logic [1:0]       a_psel = 2'd0, b_psel = 2'd0;
    logic             load_out, run_o, blank_o, sog_o, sel_o, sync_o;
    logic [RGB_W-1:0] rgb_o;

    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;
    bit         load_hold = 1'b1;
    bit         stim_on = 1'b0;
    bit         mon_on = 1'b0;
    bit         run_seen = 1'b0;
    int         load_half = 20;
    int         pat = 0;
    string      tag = "";
    logic [W-1:0] exp_q [$];

    pixmux_serializer uut (
        .pix_clk(pix_clk), .load_clk(load_clk), .rst_n(rst_n), .ratio2(ratio2),
        .sel_code(sel_code), .sog_en(sog_en), .sync_pin_en(sync_pin_en),
        .a_rgb(a_rgb), .a_sync(a_sync), .a_blank(a_blank), .a_psel(a_psel),
        .b_rgb(b_rgb), .b_sync(b_sync), .b_blank(b_blank), .b_psel(b_psel),
        .load_out(load_out), .run_o(run_o), .rgb_o(rgb_o), .blank_o(blank_o),
        .sog_o(sog_o), .sel_o(sel_o), .sync_o(sync_o)
    );

    initial forever #10 pix_clk = ~pix_clk;

    initial begin
        forever begin
            if (load_hold) begin
                load_clk = 1'b0;
                wait (!load_hold);
            end
            #(load_half) load_clk = ~load_clk;
        end
    end

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [RGB_W-1:0] rgb, input logic sy,
                                           input logic bl, input logic [1:0] ps);
        logic s;
        s = (ps == sel_code);
        return {(s && !bl && !sy) ? rgb : {RGB_W{1'b0}}, s && bl, s && sy && sog_en, s,
                sy && sync_pin_en};
    endfunction

    // stimulus: new word after each falling load edge
    always @(negedge load_clk) begin
        if (stim_on) begin
            a_rgb = RGB_W'($urandom);
            b_rgb = RGB_W'($urandom);
            case (pat)
                1: begin
                    a_psel = sel_code; b_psel = sel_code;
                    a_sync = 1'b0; a_blank = 1'b0; b_sync = 1'b0; b_blank = 1'b0;
                end
                2: begin
                    a_psel = 2'($urandom); b_psel = 2'($urandom);
                    a_sync = 1'($urandom); a_blank = 1'($urandom);
                    b_sync = 1'($urandom); b_blank = 1'($urandom);
                end
                default: begin
                    a_psel = 2'($urandom); b_psel = 2'($urandom);
                    a_sync = ($urandom % 8) == 0; a_blank = ($urandom % 6) == 0;
                    b_sync = ($urandom % 8) == 0; b_blank = ($urandom % 6) == 0;
                end
            endcase
        end
    end

    // reference: queue of expected pixels in capture order (R1)
    always @(posedge load_clk) begin
        if (rst_n && mon_on) begin
            exp_q.push_back(model(a_rgb, a_sync, a_blank, a_psel));
            if (ratio2) exp_q.push_back(model(b_rgb, b_sync, b_blank, b_psel));
        end
    end

    // comparison on every pixel clock, away from the active edge
    always @(negedge pix_clk) begin
        if (rst_n && mon_on) begin
            if (run_o) begin
                run_seen = 1'b1;
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R9 actual run_o=1 with no captured pixel expected a queued pixel");
                end else begin
                    check(tag, {1'b0, rgb_o, blank_o, sog_o, sel_o, sync_o}, {1'b0, exp_q.pop_front()});
                end
            end else if (run_seen) begin
                check("R9 run_o sticky", {{W{1'b0}}, run_o}, {{W{1'b0}}, 1'b1});
            end
        end
    end

    task automatic check_loadout();
        logic prev;
        @(negedge pix_clk);
        prev = load_out;
        for (int i = 0; i < 4; i++) begin
            @(negedge pix_clk);
            if (ratio2) begin
                check("R8 divided load clock", {{W{1'b0}}, load_out}, {{W{1'b0}}, ~prev});
                prev = load_out;
            end else begin
                check("R8 load clock low phase", {{W{1'b0}}, load_out}, {(W+1){1'b0}});
                @(posedge pix_clk);
                #5;
                check("R8 load clock high phase", {{W{1'b0}}, load_out}, {{W{1'b0}}, 1'b1});
            end
        end
    endtask

    task automatic run_scenario(input logic mode, input int ofs, input logic [1:0] code,
                                input logic sog, input logic pin, input int pattern, input int npix);
        int cyc;
        int m;
        mon_on = 1'b0; stim_on = 1'b0; rst_n = 1'b0; load_hold = 1'b1;
        ratio2 = mode; sel_code = code; sog_en = sog; sync_pin_en = pin; pat = pattern;
        load_half = mode ? 20 : 10;
        m = mode ? 2 : 1;
        tag = mode ? "R1 R2 R4 R5 R6 R7 R10" : "R1 R3 R4 R5 R6 R7 R10";
        exp_q.delete();
        run_seen = 1'b0;
        repeat (3) @(posedge pix_clk);
        @(negedge pix_clk);
        check("R9 reset state", {run_o, rgb_o, blank_o, sog_o, sel_o, sync_o}, '0);
        @(posedge pix_clk);
        #(ofs);
        load_hold = 1'b0;
        stim_on = 1'b1;
        repeat (4) @(posedge pix_clk);
        #15;
        rst_n = 1'b1;
        mon_on = 1'b1;
        cyc = 0;
        while (!run_o && cyc < 200) begin
            @(negedge pix_clk);
            cyc++;
        end
        checks++;
        if (cyc < 6 * m || cyc > 8 * m + 12) begin
            errors++;
            $display("FAIL R9 start after %0d cycles, expected between %0d and %0d", cyc, 6 * m, 8 * m + 12);
        end
        check_loadout();
        repeat (npix) @(negedge pix_clk);
        mon_on = 1'b0;
        stim_on = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge pix_clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R2, R4-R7: two-pixel mode, mixed traffic, both sync forms on
        run_scenario(1'b1, 7, 2'd2, 1'b1, 1'b1, 0, 400);
        // R4, R6, R7: all enables off, heavy sync/blank, other phase (R10)
        run_scenario(1'b1, 3, 2'd0, 1'b0, 1'b0, 2, 300);
        // R5: every pixel selected, colors pass through
        run_scenario(1'b1, 17, 2'd1, 1'b1, 1'b0, 1, 200);
        // R3: single-pixel mode, bank B must not show
        run_scenario(1'b0, 13, 2'd3, 1'b1, 1'b1, 0, 400);
        run_scenario(1'b0, 4, 2'd1, 1'b0, 1'b1, 2, 300);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule